// File: doc/BRIEF.md
# Register-Mapped TMDS Pixel Encoder

This peripheral sits on a simple register bus and turns packed colour words into 10-bit DVI video symbols for three colour lanes. Software loads a 32-bit colour word and a control word. For each lane, the control word picks a rotation of the low 16 colour bits and the number of significant colour bits to keep. Each lane then runs the standard transition-minimised, DC-balanced TMDS encoding against its own running disparity.

Results come from a group of read addresses. One read kind returns a single pixel's three symbols packed into one word. The other returns two consecutive pixels of one chosen lane. Every read kind has a peek form and a pop form. A peek has no side effect. A pop moves the colour word right by the configured pixel shift and commits the lane disparities that the returned symbols produced. A peek therefore returns exactly what the following pop will return.

Top module: `tmds_pixel_encoder`

## Requirements
- R1: After reset, every control field, the colour word and all three lane disparities are zero, and `bus_rdata` is zero.
- R2: Control word bit positions: bit 28 clear request, bit 27 no-shift, bits 26:24 shift code, bit 23 interleave flag, bits 20:18, 17:15 and 14:12 valid-bit counts for lanes 2, 1 and 0, bits 11:8, 7:4 and 3:0 rotations for lanes 2, 1 and 0. Reading the control word returns every stored field in its written position. Bit 28 and all unused bits read as zero. The colour word is write-only and reads as zero.
- R3: A lane's 8-bit colour is bits 7:0 of the low 16 colour bits right-rotated by that lane's rotation. Only its top n+1 bits are kept, where n is the lane's count field. The remaining low bits are zeroed before encoding.
- R4: A single-pixel read returns lane 0 in bits 9:0, lane 1 in bits 19:10 and lane 2 in bits 29:20. Bits 31:30 are zero.
- R5: A double read of lane k returns the first pixel's symbol in bits 9:0 and the second pixel's symbol in bits 19:10, with bits 31:20 zero. The second pixel uses the colour word shifted right by one pixel shift, or the unshifted word when no-shift is set. Its symbol is encoded after the first pixel's disparity update.
- R6: A peek read changes neither the colour word nor any lane disparity.
- R7: A single pop shifts the colour word right by the amount given by the shift code: 0 gives no shift, codes 1 to 5 give 1, 2, 4, 8 and 16 bits, and codes 6 and 7 give no shift. It commits all three lane disparities.
- R8: A double pop shifts the colour word by two pixel shifts, whatever the no-shift bit says. It commits only lane k's disparity, taking the value after the second pixel.
- R9: Each symbol follows the DVI video encoding. XOR or XNOR chaining is chosen by the count of ones, and the output is inverted or not according to the sign of the running disparity and the bias of the intermediate word.
- R10: Writing the control word with bit 28 set zeroes all three lane disparities.
- R11: Word addresses are: 0 control, 1 colour, 2/3 single peek/pop, 4/5, 6/7 and 8/9 double peek/pop for lanes 0, 1 and 2. Any other address reads zero. `bus_rdata` changes only in the cycle after a read is accepted and holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
A wrong disparity in any lane does not show at once. It shows when the next symbol's inversion choice goes wrong, and that symbol can come several pops later if the stored value happens to share the correct value's sign. The bench therefore runs long pop chains and compares every returned symbol. A wrong colour word or shift shows on the very next read, in the low lane bits, so each pop is followed by a peek. A peek that leaks state shows as a mismatch on the pop that follows it.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;

    localparam int COLOR_W  = 8;
    localparam int SYM_W    = COLOR_W + 2;
    localparam int ROT_W    = 4;
    localparam int ROT_SPAN = 1 << ROT_W;
    localparam int NB_W     = 3;
    localparam int DISP_W   = 6;
    localparam int SH_W     = 3;

    typedef logic signed [DISP_W-1:0] disp_t;

    typedef struct packed {
        logic [SYM_W-1:0] sym;
        disp_t            disp;
    } enc_res_t;

    // DVI video-period encoding of one colour byte against a running disparity
    function automatic enc_res_t tmds_encode(input logic [COLOR_W-1:0] d, input disp_t cnt);
        enc_res_t       r;
        logic [COLOR_W:0] qm;
        logic           use_xnor;
        int             ones_d;
        int             bias;
        int             c;
        int             q8;
        ones_d   = $countones(d);
        use_xnor = (ones_d > COLOR_W / 2) || (ones_d == COLOR_W / 2 && !d[0]);
        qm[0]    = d[0];
        for (int i = 1; i < COLOR_W; i++) begin
            qm[i] = use_xnor ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
        end
        qm[COLOR_W] = ~use_xnor;
        q8   = qm[COLOR_W] ? 1 : 0;
        bias = 2 * $countones(qm[COLOR_W-1:0]) - COLOR_W;
        c    = int'(cnt);
        if (c == 0 || bias == 0) begin
            r.sym  = {~qm[COLOR_W], qm[COLOR_W], qm[COLOR_W] ? qm[COLOR_W-1:0] : ~qm[COLOR_W-1:0]};
            r.disp = disp_t'(qm[COLOR_W] ? c + bias : c - bias);
        end else if ((c > 0 && bias > 0) || (c < 0 && bias < 0)) begin
            r.sym  = {1'b1, qm[COLOR_W], ~qm[COLOR_W-1:0]};
            r.disp = disp_t'(c + 2 * q8 - bias);
        end else begin
            r.sym  = {1'b0, qm[COLOR_W], qm[COLOR_W-1:0]};
            r.disp = disp_t'(c - 2 * (1 - q8) + bias);
        end
        return r;
    endfunction

endpackage

// File: rtl/tmds_pix_shift.sv
module tmds_pix_shift #(
    parameter int DATA_W = 32,
    parameter int CODE_W = 3
) (
    input  logic [DATA_W-1:0] col,
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] once,
    output logic [DATA_W-1:0] twice
);
    localparam int MAX_CODE = $clog2(DATA_W);
    localparam int AMT_W    = $clog2(DATA_W) + 1;

    logic [AMT_W-1:0] amt;

    always_comb begin
        amt = '0;
        if (code != '0 && int'(code) <= MAX_CODE) begin
            amt = AMT_W'(1) << (code - CODE_W'(1));
        end
    end

    assign once  = col >> amt;
    assign twice = once >> amt;
endmodule

// File: rtl/tmds_lane_pick.sv
module tmds_lane_pick
    import tmds_enc_pkg::*;
(
    input  logic [ROT_SPAN-1:0] col,
    input  logic [ROT_W-1:0]    rot,
    input  logic [NB_W-1:0]     nbits,
    output logic [COLOR_W-1:0]  value
);
    logic [2*ROT_SPAN-1:0] doubled;
    logic [COLOR_W-1:0]    low_bits;
    logic [COLOR_W-1:0]    keep;

    assign doubled  = {col, col};
    assign low_bits = COLOR_W'(doubled >> rot);
    assign keep     = {COLOR_W{1'b1}} << (NB_W'(COLOR_W - 1) - nbits);
    assign value    = low_bits & keep;
endmodule

// File: rtl/tmds_lane_pair.sv
module tmds_lane_pair
    import tmds_enc_pkg::*;
(
    input  logic [ROT_SPAN-1:0] col_a,
    input  logic [ROT_SPAN-1:0] col_b,
    input  logic [ROT_W-1:0]    rot,
    input  logic [NB_W-1:0]     nbits,
    input  disp_t               disp_in,
    output logic [SYM_W-1:0]    sym_a,
    output logic [SYM_W-1:0]    sym_b,
    output disp_t               disp_a,
    output disp_t               disp_b
);
    logic [COLOR_W-1:0] val_a;
    logic [COLOR_W-1:0] val_b;
    enc_res_t           res_a;
    enc_res_t           res_b;

    tmds_lane_pick u_pick_a (.col(col_a), .rot(rot), .nbits(nbits), .value(val_a));
    tmds_lane_pick u_pick_b (.col(col_b), .rot(rot), .nbits(nbits), .value(val_b));

    always_comb begin
        res_a = tmds_encode(val_a, disp_in);
        res_b = tmds_encode(val_b, res_a.disp);
    end

    assign sym_a  = res_a.sym;
    assign sym_b  = res_b.sym;
    assign disp_a = res_a.disp;
    assign disp_b = res_b.disp;
endmodule

// File: rtl/tmds_pixel_encoder.sv
module tmds_pixel_encoder
    import tmds_enc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int LANES       = 3;
    localparam int CLR_BIT     = 28;
    localparam int NOSHIFT_BIT = 27;
    localparam int SH_LSB      = 24;
    localparam int ILV_BIT     = 23;
    localparam int NB_LSB      = 12;
    localparam int ROT_LSB     = 0;
    localparam int SINGLE_PAIR = 1;
    localparam int DOUBLE_BASE = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_COLOUR = ADDR_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0]                  colour;
        logic                               noshift;
        logic [SH_W-1:0]                    shcode;
        logic                               ilv;
        logic [LANES-1:0][NB_W-1:0]         nbits;
        logic [LANES-1:0][ROT_W-1:0]        rot;
        logic [LANES-1:0][DISP_W-1:0]       disp;
        logic [DATA_W-1:0]                  rdata;
    } st_t;

    st_t st_d;
    st_t st_q;

    logic [DATA_W-1:0]             shift_one;
    logic [DATA_W-1:0]             shift_two;
    logic [ROT_SPAN-1:0]           col_second;
    logic [LANES-1:0][SYM_W-1:0]   sym_a;
    logic [LANES-1:0][SYM_W-1:0]   sym_b;
    logic [LANES-1:0][DISP_W-1:0]  disp_a;
    logic [LANES-1:0][DISP_W-1:0]  disp_b;
    logic [DATA_W-1:0]             ctrl_word;
    logic                          clear_req;

    tmds_pix_shift #(.DATA_W(DATA_W), .CODE_W(SH_W)) u_shift (
        .col  (st_q.colour),
        .code (st_q.shcode),
        .once (shift_one),
        .twice(shift_two)
    );

    assign col_second = st_q.noshift ? st_q.colour[ROT_SPAN-1:0] : shift_one[ROT_SPAN-1:0];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tmds_lane_pair u_pair (
            .col_a  (st_q.colour[ROT_SPAN-1:0]),
            .col_b  (col_second),
            .rot    (st_q.rot[l]),
            .nbits  (st_q.nbits[l]),
            .disp_in(st_q.disp[l]),
            .sym_a  (sym_a[l]),
            .sym_b  (sym_b[l]),
            .disp_a (disp_a[l]),
            .disp_b (disp_b[l])
        );
    end

    always_comb begin
        ctrl_word                                = '0;
        ctrl_word[NOSHIFT_BIT]                   = st_q.noshift;
        ctrl_word[SH_LSB +: SH_W]                = st_q.shcode;
        ctrl_word[ILV_BIT]                       = st_q.ilv;
        ctrl_word[NB_LSB +: LANES*NB_W]          = st_q.nbits;
        ctrl_word[ROT_LSB +: LANES*ROT_W]        = st_q.rot;
    end

    always_comb begin
        st_d      = st_q;
        clear_req = 1'b0;

        if (bus_rd_en) begin
            st_d.rdata = '0;
            if (bus_addr == A_CTRL) begin
                st_d.rdata = ctrl_word;
            end
            if (int'(bus_addr[ADDR_W-1:1]) == SINGLE_PAIR) begin
                st_d.rdata = DATA_W'(sym_a);
                if (bus_addr[0]) begin
                    st_d.colour = shift_one;
                    st_d.disp   = disp_a;
                end
            end
            for (int l = 0; l < LANES; l++) begin
                if (int'(bus_addr[ADDR_W-1:1]) == DOUBLE_BASE + l) begin
                    st_d.rdata = DATA_W'({sym_b[l], sym_a[l]});
                    if (bus_addr[0]) begin
                        st_d.colour  = shift_two;
                        st_d.disp[l] = disp_b[l];
                    end
                end
            end
        end

        if (bus_wr_en) begin
            if (bus_addr == A_CTRL) begin
                st_d.noshift = bus_wdata[NOSHIFT_BIT];
                st_d.shcode  = bus_wdata[SH_LSB +: SH_W];
                st_d.ilv     = bus_wdata[ILV_BIT];
                st_d.nbits   = bus_wdata[NB_LSB +: LANES*NB_W];
                st_d.rot     = bus_wdata[ROT_LSB +: LANES*ROT_W];
                clear_req    = bus_wdata[CLR_BIT];
            end
            if (bus_addr == A_COLOUR) begin
                st_d.colour = bus_wdata;
            end
        end

        if (clear_req) begin
            st_d.disp = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/tmds_pixel_encoder_chk.sv
module tmds_pixel_encoder_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int DISP_W = 6,
    parameter int LANES  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr_en,
    input logic                    bus_rd_en,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [DATA_W-1:0]       bus_wdata,
    input logic [DATA_W-1:0]       bus_rdata,
    input logic [DATA_W-1:0]       colour_obs,
    input logic [LANES*DISP_W-1:0] disp_obs
);
    logic is_peek;
    logic is_single;
    logic is_double;
    logic clear_wr;
    logic colour_wr;

    assign is_peek   = bus_rd_en && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(4) ||
                                     bus_addr == ADDR_W'(6) || bus_addr == ADDR_W'(8));
    assign is_single = bus_rd_en && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3));
    assign is_double = bus_rd_en && bus_addr >= ADDR_W'(4) && bus_addr <= ADDR_W'(9);
    assign clear_wr  = bus_wr_en && bus_addr == ADDR_W'(0) && bus_wdata[28];
    assign colour_wr = bus_wr_en && bus_addr == ADDR_W'(1);

    assert_peek_colour_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_peek && !colour_wr |=> $stable(colour_obs));

    assert_peek_disp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_peek && !clear_wr |=> $stable(disp_obs));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));

    assert_clear_disp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_wr |=> disp_obs == '0);

    assert_single_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_single |=> bus_rdata[DATA_W-1:30] == '0);

    assert_double_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_double |=> bus_rdata[DATA_W-1:20] == '0);

    assert_colour_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        colour_wr |=> colour_obs == $past(bus_wdata));

    for (genvar l = 0; l < LANES; l++) begin : g_bound
        assert_disp_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $signed(disp_obs[l*DISP_W +: DISP_W]) <= 16 &&
            $signed(disp_obs[l*DISP_W +: DISP_W]) >= -16);
    end
endmodule

bind tmds_pixel_encoder tmds_pixel_encoder_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .colour_obs(st_q.colour),
    .disp_obs  (st_q.disp)
);

// File: tb/tb_tmds_pixel_encoder.sv
`timescale 1ns/1ps
module tb_tmds_pixel_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [31:0] m_ctrl = '0;
    logic [31:0] m_colour = '0;
    int          m_disp [3] = '{0, 0, 0};

    always #4 clk = ~clk;

    tmds_pixel_encoder dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // ---------------- reference model ----------------
    function automatic logic [31:0] mk_ctrl(input int r0, input int r1, input int r2,
                                            input int n0, input int n1, input int n2,
                                            input int code, input int ns);
        logic [31:0] v;
        v = '0;
        v[3:0] = 4'(r0);  v[7:4] = 4'(r1);  v[11:8] = 4'(r2);
        v[14:12] = 3'(n0); v[17:15] = 3'(n1); v[20:18] = 3'(n2);
        v[26:24] = 3'(code); v[27] = (ns != 0);
        return v;
    endfunction

    function automatic logic [7:0] ref_pick(input logic [31:0] c, input int rot, input int nb);
        logic [15:0] lo;
        logic [15:0] r;
        logic [7:0]  v;
        lo = c[15:0];
        r  = (rot == 0) ? lo : ((lo >> rot) | (lo << (16 - rot)));
        v  = r[7:0];
        for (int b = 0; b < 8; b++) if (b < 7 - nb) v[b] = 1'b0;
        return v;
    endfunction

    function automatic logic [9:0] ref_sym(input logic [7:0] d, inout int rd);
        int n1;
        int nm;
        int bal;
        logic inv;
        logic [8:0] m;
        logic [9:0] s;
        n1 = 0;
        for (int i = 0; i < 8; i++) n1 += int'(d[i]);
        inv = (n1 > 4) || (n1 == 4 && d[0] == 1'b0);
        m[0] = d[0];
        for (int i = 1; i < 8; i++) m[i] = m[i-1] ^ d[i] ^ inv;
        m[8] = !inv;
        nm = 0;
        for (int i = 0; i < 8; i++) nm += int'(m[i]);
        bal = nm - (8 - nm);
        if (rd == 0 || bal == 0) begin
            if (m[8]) begin s = {2'b01, m[7:0]}; rd = rd + bal; end
            else      begin s = {2'b10, ~m[7:0]}; rd = rd - bal; end
        end else if ((rd > 0) == (bal > 0)) begin
            s = {1'b1, m[8], ~m[7:0]};
            rd = rd + (m[8] ? 2 : 0) - bal;
        end else begin
            s = {1'b0, m[8], m[7:0]};
            rd = rd + bal - (m[8] ? 0 : 2);
        end
        return s;
    endfunction

    function automatic int ref_amt(input logic [2:0] code);
        case (code)
            3'd1: return 1;
            3'd2: return 2;
            3'd3: return 4;
            3'd4: return 8;
            3'd5: return 16;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input int addr);
        int d [3];
        logic [31:0] e;
        logic [31:0] cb;
        int amt;
        int l;
        logic [9:0] s0;
        logic [9:0] s1;
        for (int k = 0; k < 3; k++) d[k] = m_disp[k];
        e = '0;
        amt = ref_amt(m_ctrl[26:24]);
        if (addr == 0) e = m_ctrl;
        else if (addr == 2 || addr == 3) begin
            for (int k = 0; k < 3; k++) begin
                s0 = ref_sym(ref_pick(m_colour, int'(m_ctrl[4*k +: 4]), int'(m_ctrl[12+3*k +: 3])), d[k]);
                e[10*k +: 10] = s0;
            end
            if (addr == 3) begin
                for (int k = 0; k < 3; k++) m_disp[k] = d[k];
                m_colour = m_colour >> amt;
            end
        end else if (addr >= 4 && addr <= 9) begin
            l  = (addr - 4) / 2;
            cb = m_ctrl[27] ? m_colour : (m_colour >> amt);
            s0 = ref_sym(ref_pick(m_colour, int'(m_ctrl[4*l +: 4]), int'(m_ctrl[12+3*l +: 3])), d[l]);
            s1 = ref_sym(ref_pick(cb, int'(m_ctrl[4*l +: 4]), int'(m_ctrl[12+3*l +: 3])), d[l]);
            e[19:0] = {s1, s0};
            if (addr % 2 == 1) begin
                m_disp[l] = d[l];
                m_colour  = (m_colour >> amt) >> amt;
            end
        end
        return e;
    endfunction

    // ---------------- bus helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 4'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr_en = 1'b0;
        if (addr == 0) begin
            m_ctrl = data & 32'h0F9F_FFFF;
            if (data[28]) for (int k = 0; k < 3; k++) m_disp[k] = 0;
        end else if (addr == 1) begin
            m_colour = data;
        end
    endtask

    task automatic bus_rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = 4'(addr);
        @(negedge clk);
        bus_rd_en = 1'b0;
        data = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input int addr);
        logic [31:0] exp;
        logic [31:0] act;
        exp = model_read(addr);
        bus_rd(addr, act);
        check(req, act, exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R1 read data after reset", bus_rdata, 32'h0);
        rd_chk("R1 control reads zero after reset", 0);
        check("R1 model control is zero", m_ctrl, 32'h0);
        rd_chk("R1 reset peek single of zero colour", 2);
    endtask

    task automatic t_ctrl();
        logic [31:0] act;
        bus_wr(0, 32'hFFFF_FFFF);
        bus_rd(0, act);
        check("R2 control readback layout", act, 32'h0F9F_FFFF);
        bus_wr(1, 32'hDEAD_BEEF);
        rd_chk("R2 colour word reads zero", 1);
        bus_wr(0, 32'h0);
        rd_chk("R2 control cleared", 0);
    endtask

    task automatic t_extract();
        bus_wr(0, mk_ctrl(0, 4, 8, 7, 7, 7, 0, 0));
        bus_wr(1, 32'h0000_A5C3);
        rd_chk("R3 R4 full width lanes at rot 0/4/8", 2);
        bus_wr(0, mk_ctrl(12, 15, 3, 2, 0, 5, 0, 0));
        bus_wr(1, 32'h1234_3C96);
        rd_chk("R3 wrapped rotation and masking", 2);
        bus_wr(0, mk_ctrl(1, 7, 13, 7, 3, 6, 0, 0));
        bus_wr(1, 32'hFFFF_8001);
        rd_chk("R3 upper colour bits ignored", 2);
        bus_wr(0, mk_ctrl(0, 8, 4, 7, 7, 7, 0, 0));
        bus_wr(1, 32'h0000_F00F);
        rd_chk("R4 distinct lanes in packed fields", 2);
    endtask

    task automatic t_pop_single();
        for (int code = 0; code < 7; code++) begin
            bus_wr(0, mk_ctrl(0, 8, 4, 7, 7, 7, code, 0));
            bus_wr(1, 32'h9ABC_DEF1);
            rd_chk("R7 single pop symbols", 3);
            rd_chk("R7 peek after single pop shows shift", 2);
        end
    endtask

    task automatic t_double();
        bus_wr(0, mk_ctrl(0, 4, 8, 7, 7, 7, 2, 0));
        bus_wr(1, 32'h5A3C_96E1);
        rd_chk("R5 double peek lane 1 shifted second pixel", 6);
        rd_chk("R8 double pop lane 0", 5);
        rd_chk("R8 single peek after double pop", 2);
        bus_wr(0, mk_ctrl(0, 4, 8, 7, 7, 7, 3, 1));
        rd_chk("R5 double peek lane 2 with no-shift", 8);
        rd_chk("R8 double pop lane 2 with no-shift", 9);
        rd_chk("R8 double peek lane 2 after pop", 8);
        rd_chk("R8 other lanes untouched", 2);
    endtask

    task automatic t_peek();
        bus_wr(0, mk_ctrl(3, 9, 14, 7, 6, 5, 4, 0));
        bus_wr(1, 32'h3E71_C2A9);
        rd_chk("R6 first peek", 2);
        rd_chk("R6 repeated peek identical", 2);
        rd_chk("R6 double peek lane 0", 4);
        rd_chk("R6 pop equals preceding peeks", 3);
    endtask

    task automatic t_disp();
        bus_wr(0, mk_ctrl(0, 5, 11, 7, 7, 7, 0, 0));
        for (int i = 0; i < 16; i++) begin
            bus_wr(1, 32'h1F3A_7C55 ^ (32'(i) * 32'h0107_1F3B));
            rd_chk("R9 running disparity chain", 3);
        end
        for (int i = 0; i < 6; i++) begin
            bus_wr(1, (i % 2 == 0) ? 32'h0000_FFFF : 32'h0000_0101);
            rd_chk("R9 biased colour chain", 3);
        end
    endtask

    task automatic t_clear();
        bus_wr(1, 32'h0000_FFFF);
        rd_chk("R9 build disparity", 3);
        bus_wr(1, 32'h0000_FFFF);
        bus_wr(0, mk_ctrl(0, 5, 11, 7, 7, 7, 0, 0) | 32'h1000_0000);
        rd_chk("R10 peek after clear uses zero disparity", 2);
        rd_chk("R10 R2 clear bit reads zero", 0);
    endtask

    task automatic t_hold();
        logic [31:0] held;
        rd_chk("R11 read before hold", 2);
        held = bus_rdata;
        repeat (4) @(negedge clk);
        check("R11 rdata holds while idle", bus_rdata, held);
        bus_wr(1, 32'h0F0F_0F0F);
        check("R11 rdata holds across write", bus_rdata, held);
        rd_chk("R11 unmapped address reads zero", 12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_extract();
        t_pop_single();
        t_double();
        t_peek();
        t_disp();
        t_clear();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule